// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block pulls characters off an asynchronous serial input. A divider elsewhere supplies a one-cycle enable called the sample tick. On each tick the receiver takes one sample of the line, and each bit period spans 8 or 16 ticks. A falling edge on the line starts a frame candidate. The candidate becomes a start bit only if the line is still low at the centre of that bit. Each data, parity and stop bit is then decided by a majority vote over three samples around the bit centre.

The frame format is set by static configuration inputs:
- 5 to 9 data bits;
- an optional even or odd parity bit;
- least- or most-significant bit first.

Each finished character goes into a holding register together with its status flags: parity error, framing error, overrun and break. The same read strobe that consumes the character clears all of these flags. A receiver time-out flag rises when the line has been idle for a programmable number of bit periods after the last character.

Top module: `osrx`

## Requirements
- R1: The oversampling factor is 16 when `cfg_os16` is 1 and 8 otherwise. A low sample while idle starts a candidate and counts as sample 0 of the start bit. The start bit is confirmed only if the line is low at sample 8 (16x) or sample 4 (8x). If the line is high there, the receiver returns to idle and produces no character.
- R2: Each data, parity and stop bit takes the majority value of the samples at positions H-1, H and H+1 of its bit period, where H is 8 (16x) or 4 (8x). A single inverted sample among those three does not change the bit.
- R3: The character length is `cfg_nbits`, from 5 to 9 (values outside this range are clamped). The received bits appear right-aligned in `rx_data`, and all higher bits read 0.
- R4: When `cfg_msb_first` is 0, the first data bit on the line lands in `rx_data[0]`. When it is 1, the first data bit lands in `rx_data[cfg_nbits-1]`.
- R5: With `cfg_par_en` set, one parity bit follows the data. With `cfg_par_odd` at 0 the data plus parity must hold an even number of ones, and with it at 1 an odd number. A mismatch sets `err_parity`. With `cfg_par_en` clear, no parity bit is expected and `err_parity` stays 0.
- R6: A stop bit voted low sets `err_frame` with that character.
- R7: If a character completes while `rx_valid` is still set and no read happens in that cycle, `err_overrun` sets and the new character replaces the old one.
- R8: If every data bit, the parity bit and the stop bit are all voted 0, the receiver flags a break. It sets `brk_det` and `err_frame`, and `rx_data` reads 0. It then ignores the line until a high sample, so a held-low line produces no further characters.
- R9: A completed character sets `rx_valid`. A cycle with `rd_stb` high and no completion clears `rx_valid`, `err_parity`, `err_frame`, `err_overrun`, `brk_det` and `rx_timeout`.
- R10: After a character, `rx_timeout` rises on the idle tick that makes `cfg_to_bits` × OS idle ticks since completion, where OS is the oversampling factor. It stays set until `rd_stb`, and fires at most once per received character.
- R11: `rx_timeout` never rises while `cfg_to_bits` is 0, nor before the first character after reset.
- R12: After reset, `rx_valid`, every status flag and `rx_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable, one per oversample period |
| rx | input | 1 | Serial line, idle high |
| cfg_os16 | input | 1 | 1: 16 samples per bit, 0: 8 |
| cfg_nbits | input | 4 | Data bits per character (5..9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_to_bits | input | 8 | Idle time-out in bit periods, 0 disables |
| rd_stb | input | 1 | Consume character and clear flags |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Character waiting |
| err_parity | output | 1 | Parity mismatch |
| err_frame | output | 1 | Stop bit low |
| err_overrun | output | 1 | Character lost to an unread one |
| brk_det | output | 1 | Break received |
| rx_timeout | output | 1 | Idle time-out expired |

## Verification
The hardest situation to reach is the break path. A line held low has to pass through a confirmed start bit, every data position, the parity bit and the stop vote. The receiver must then stay silent while the line remains low, even after the break character has been read. The stimulus holds the line low well past one frame, reads the character, holds the line low for three more bit periods and checks that nothing new arrives. It then releases the line and receives a normal frame. The time-out boundary is hit by counting idle ticks exactly from the stop-bit vote and checking both one tick short of the limit and at the limit.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  localparam int unsigned OS_MAX = 16;
  localparam int unsigned SW     = $clog2(OS_MAX);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRKW
  } rx_state_e;
endpackage

// File: rtl/osrx_sampler.sv
module osrx_sampler
  import osrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic os16,
  input  logic arm,
  input  logic hold,
  output logic mid_stb,
  output logic vote_stb,
  output logic vote_bit,
  output logic wrap_stb
);
  logic [SW-1:0] s_q, s_d;
  logic [SW-1:0] half, last;
  logic [1:0]    ones_q, ones_d;
  logic          live;

  assign half = os16 ? SW'(OS_MAX / 2) : SW'(OS_MAX / 4);
  assign last = os16 ? SW'(OS_MAX - 1) : SW'(OS_MAX / 2 - 1);
  assign live = tick & ~hold;

  // position within the current bit period
  always_comb begin
    s_d = s_q;
    if (arm)
      s_d = SW'(1);
    else if (hold)
      s_d = '0;
    else if (tick)
      s_d = (s_q == last) ? '0 : s_q + 1'b1;
  end

  // ones seen among the samples before the centre and at it
  always_comb begin
    ones_d = ones_q;
    if (live) begin
      if (s_q == half - 1'b1)
        ones_d = {1'b0, rx};
      else if (s_q == half)
        ones_d = ones_q + {1'b0, rx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= '0;
      ones_q <= '0;
    end else begin
      s_q    <= s_d;
      ones_q <= ones_d;
    end
  end

  assign mid_stb  = live & (s_q == half);
  assign vote_stb = live & (s_q == half + 1'b1);
  assign vote_bit = ones_q[1] | (ones_q[0] & rx);
  assign wrap_stb = live & (s_q == last);
endmodule

// File: rtl/osrx_frame.sv
module osrx_frame
  import osrx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 9,
  localparam int unsigned NB_W    = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  logic [NB_W-1:0]     cfg_nbits,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                msb_first,
  input  logic                mid_stb,
  input  logic                vote_stb,
  input  logic                vote_bit,
  input  logic                wrap_stb,
  output logic                arm,
  output logic                hold,
  output logic                idle,
  output logic                commit,
  output logic [MAX_BITS-1:0] c_data,
  output logic                c_perr,
  output logic                c_ferr,
  output logic                c_brk
);
  rx_state_e            state_q, state_d;
  logic [IDX_W-1:0]     bidx_q, bidx_d;
  logic [MAX_BITS-1:0]  data_q, data_d;
  logic                 par_q, par_d;
  logic                 allz_q, allz_d;
  logic                 perr_q, perr_d;
  logic [NB_W-1:0]      nb_eff;
  logic [IDX_W-1:0]     last_idx, wr_idx;

  always_comb begin
    nb_eff = cfg_nbits;
    if (cfg_nbits < NB_W'(5))
      nb_eff = NB_W'(5);
    else if (cfg_nbits > NB_W'(MAX_BITS))
      nb_eff = NB_W'(MAX_BITS);
  end

  assign last_idx = IDX_W'(nb_eff - 1'b1);
  assign wr_idx   = msb_first ? last_idx - bidx_q : bidx_q;

  always_comb begin
    state_d = state_q;
    bidx_d  = bidx_q;
    data_d  = data_q;
    par_d   = par_q;
    allz_d  = allz_q;
    perr_d  = perr_q;
    case (state_q)
      RX_IDLE: begin
        if (tick && !rx)
          state_d = RX_START;
      end
      RX_START: begin
        if (mid_stb && rx) begin
          state_d = RX_IDLE;
        end else if (wrap_stb) begin
          state_d = RX_DATA;
          bidx_d  = '0;
          data_d  = '0;
          par_d   = 1'b0;
          allz_d  = 1'b1;
          perr_d  = 1'b0;
        end
      end
      RX_DATA: begin
        if (vote_stb) begin
          data_d[wr_idx] = vote_bit;
          par_d          = par_q ^ vote_bit;
          allz_d         = allz_q & ~vote_bit;
        end
        if (wrap_stb) begin
          if (bidx_q == last_idx)
            state_d = par_en ? RX_PAR : RX_STOP;
          else
            bidx_d = bidx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (vote_stb) begin
          perr_d = par_q ^ vote_bit ^ par_odd;
          allz_d = allz_q & ~vote_bit;
        end
        if (wrap_stb)
          state_d = RX_STOP;
      end
      RX_STOP: begin
        if (vote_stb)
          state_d = (allz_q && !vote_bit) ? RX_BRKW : RX_IDLE;
      end
      RX_BRKW: begin
        if (tick && rx)
          state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bidx_q  <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      allz_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bidx_q  <= bidx_d;
      data_q  <= data_d;
      par_q   <= par_d;
      allz_q  <= allz_d;
      perr_q  <= perr_d;
    end
  end

  assign idle   = (state_q == RX_IDLE);
  assign hold   = idle | (state_q == RX_BRKW);
  assign arm    = idle & tick & ~rx;
  assign commit = (state_q == RX_STOP) & vote_stb;
  assign c_data = data_q;
  assign c_perr = par_en & perr_q;
  assign c_ferr = ~vote_bit;
  assign c_brk  = allz_q & ~vote_bit;
endmodule

// File: rtl/osrx_timeout.sv
module osrx_timeout
  import osrx_pkg::*;
#(
  parameter int unsigned TO_W = 8,
  localparam int unsigned CW  = TO_W + SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            idle,
  input  logic            commit,
  input  logic            clr,
  input  logic            os16,
  input  logic [TO_W-1:0] cfg_to_bits,
  output logic            to_flag
);
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          flag_d;
  logic          fire;

  assign limit = os16 ? (CW'(cfg_to_bits) << SW) : (CW'(cfg_to_bits) << (SW - 1));
  assign fire  = idle & armed_q & tick & (limit != '0) & (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    flag_d  = to_flag;
    if (commit || !idle)
      cnt_d = '0;
    else if (tick && armed_q && (limit != '0))
      cnt_d = fire ? '0 : cnt_q + 1'b1;
    if (commit)
      armed_d = 1'b1;
    else if (fire)
      armed_d = 1'b0;
    if (fire)
      flag_d = 1'b1;
    else if (clr)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      to_flag <= flag_d;
    end
  end
endmodule

// File: rtl/osrx.sv
module osrx
  import osrx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned TO_W     = 8,
  localparam int unsigned NB_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  logic                cfg_os16,
  input  logic [NB_W-1:0]     cfg_nbits,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_msb_first,
  input  logic [TO_W-1:0]     cfg_to_bits,
  input  logic                rd_stb,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                brk_det,
  output logic                rx_timeout
);
  logic [1:0]          rst_sync;
  logic                rst_n_s;
  logic                arm_w, hold_w, idle_w, commit_w;
  logic                mid_w, vote_stb_w, vote_bit_w, wrap_w;
  logic [MAX_BITS-1:0] c_data_w;
  logic                c_perr_w, c_ferr_w, c_brk_w;

  logic [MAX_BITS-1:0] data_d;
  logic                valid_d, perr_d, ferr_d, ovr_d, brk_d;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  osrx_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick),
    .rx       (rx),
    .os16     (cfg_os16),
    .arm      (arm_w),
    .hold     (hold_w),
    .mid_stb  (mid_w),
    .vote_stb (vote_stb_w),
    .vote_bit (vote_bit_w),
    .wrap_stb (wrap_w)
  );

  osrx_frame #(.MAX_BITS(MAX_BITS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick      (tick),
    .rx        (rx),
    .cfg_nbits (cfg_nbits),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .msb_first (cfg_msb_first),
    .mid_stb   (mid_w),
    .vote_stb  (vote_stb_w),
    .vote_bit  (vote_bit_w),
    .wrap_stb  (wrap_w),
    .arm       (arm_w),
    .hold      (hold_w),
    .idle      (idle_w),
    .commit    (commit_w),
    .c_data    (c_data_w),
    .c_perr    (c_perr_w),
    .c_ferr    (c_ferr_w),
    .c_brk     (c_brk_w)
  );

  osrx_timeout #(.TO_W(TO_W)) u_timeout (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick        (tick),
    .idle        (idle_w),
    .commit      (commit_w),
    .clr         (rd_stb),
    .os16        (cfg_os16),
    .cfg_to_bits (cfg_to_bits),
    .to_flag     (rx_timeout)
  );

  // holding register: a completion takes priority over a read
  always_comb begin
    data_d  = rx_data;
    valid_d = rx_valid;
    perr_d  = err_parity;
    ferr_d  = err_frame;
    ovr_d   = err_overrun;
    brk_d   = brk_det;
    if (commit_w) begin
      data_d  = c_data_w;
      valid_d = 1'b1;
      perr_d  = c_perr_w;
      ferr_d  = c_ferr_w;
      brk_d   = c_brk_w;
      ovr_d   = (err_overrun | rx_valid) & ~rd_stb;
    end else if (rd_stb) begin
      valid_d = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
      ovr_d   = 1'b0;
      brk_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      brk_det     <= 1'b0;
    end else begin
      rx_data     <= data_d;
      rx_valid    <= valid_d;
      err_parity  <= perr_d;
      err_frame   <= ferr_d;
      err_overrun <= ovr_d;
      brk_det     <= brk_d;
    end
  end
endmodule

// File: rtl/osrx_chk.sv
module osrx_chk #(
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned TO_W     = 8,
  parameter int unsigned NB_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_stb,
  input logic                commit,
  input logic                cfg_par_en,
  input logic [NB_W-1:0]     cfg_nbits,
  input logic [TO_W-1:0]     cfg_to_bits,
  input logic [MAX_BITS-1:0] rx_data,
  input logic                rx_valid,
  input logic                err_parity,
  input logic                err_frame,
  input logic                err_overrun,
  input logic                brk_det,
  input logic                rx_timeout
);
  p_commit_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rx_valid);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !commit) |=> (!rx_valid && !err_overrun && !brk_det && !rx_timeout));

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rx_valid && !rd_stb) |=> err_overrun);

  p_break_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> err_frame);

  p_parity_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cfg_par_en) |=> !err_parity);

  p_short_char_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cfg_nbits == NB_W'(5)) |=> (rx_data[MAX_BITS-1:5] == '0));

  p_timeout_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_timeout && !rd_stb) |=> rx_timeout);

  p_timeout_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_timeout && cfg_to_bits == '0) |=> !rx_timeout);
endmodule

bind osrx osrx_chk #(
  .MAX_BITS (MAX_BITS),
  .TO_W     (TO_W),
  .NB_W     (NB_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb      (rd_stb),
  .commit      (commit_w),
  .cfg_par_en  (cfg_par_en),
  .cfg_nbits   (cfg_nbits),
  .cfg_to_bits (cfg_to_bits),
  .rx_data     (rx_data),
  .rx_valid    (rx_valid),
  .err_parity  (err_parity),
  .err_frame   (err_frame),
  .err_overrun (err_overrun),
  .brk_det     (brk_det),
  .rx_timeout  (rx_timeout)
);

// File: tb/osrx_tb.sv
`timescale 1ns/1ps
module osrx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, rx, rd_stb;
  logic       cfg_os16, cfg_par_en, cfg_par_odd, cfg_msb_first;
  logic [3:0] cfg_nbits;
  logic [7:0] cfg_to_bits;
  logic [8:0] rx_data;
  logic       rx_valid, err_parity, err_frame, err_overrun, brk_det, rx_timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  osrx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
    .cfg_os16(cfg_os16), .cfg_nbits(cfg_nbits), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_msb_first(cfg_msb_first),
    .cfg_to_bits(cfg_to_bits), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det),
    .rx_timeout(rx_timeout)
  );

  typedef struct packed {
    logic       os16;
    logic [3:0] nb;
    logic       pen;
    logic       podd;
    logic       msb;
    logic [8:0] word;
    logic       pbit;
    logic       stop;
    logic       glitch;
    logic       eperr;
    logic       eferr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd5, 1'b0, 1'b0, 1'b0, 9'h015, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd9, 1'b0, 1'b0, 1'b0, 9'h1A3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd7, 1'b0, 1'b0, 1'b1, 9'h045, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd6, 1'b0, 1'b0, 1'b1, 9'h029, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 9'h001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 4'd8, 1'b1, 1'b1, 1'b0, 9'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd8, 1'b1, 1'b1, 1'b0, 9'h003, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 4'd6, 1'b0, 1'b0, 1'b0, 9'h02A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 4'd8, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 4'd8, 1'b0, 1'b0, 1'b1, 9'h0C3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    @(negedge clk);
    rx   = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int os, input logic g);
    for (int k = 0; k < os; k++)
      smp((g && k == os / 2 - 1) ? ~b : b);
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_os16      = v.os16;
    cfg_nbits     = v.nb;
    cfg_par_en    = v.pen;
    cfg_par_odd   = v.podd;
    cfg_msb_first = v.msb;
  endtask

  task automatic send_frame(input vec_t v, input int gap);
    int os;
    os = v.os16 ? 16 : 8;
    send_bit(1'b0, os, 1'b0);
    for (int i = 0; i < int'(v.nb); i++)
      send_bit(v.msb ? v.word[int'(v.nb) - 1 - i] : v.word[i], os, v.glitch);
    if (v.pen)
      send_bit(v.pbit, os, v.glitch);
    send_bit(v.stop, os, 1'b0);
    for (int i = 0; i < gap; i++)
      smp(1'b1);
  endtask

  task automatic rd();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic vec_t mk(input logic os16, input logic [3:0] nb, input logic pen,
                              input logic [8:0] word, input logic pbit);
    vec_t v;
    v = '{os16, nb, pen, 1'b0, 1'b0, word, pbit, 1'b1, 1'b0, 1'b0, 1'b0};
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    string tag;
    rst_n = 1'b0; tick = 1'b0; rx = 1'b1; rd_stb = 1'b0;
    cfg_os16 = 1'b0; cfg_nbits = 4'd8; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_msb_first = 1'b0; cfg_to_bits = 8'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 valid", {31'd0, rx_valid}, 32'd0);
    chk("R12 flags", {27'd0, err_parity, err_frame, err_overrun, brk_det, rx_timeout}, 32'd0);

    // R11 no time-out before any character
    for (int i = 0; i < 100; i++) smp(1'b1);
    chk("R11 before first char", {31'd0, rx_timeout}, 32'd0);
    cfg_to_bits = 8'd0;

    // R1 short low pulse rejected at the centre sample (8x: high at sample 4)
    for (int i = 0; i < 3; i++) smp(1'b0);
    for (int i = 0; i < 30; i++) smp(1'b1);
    chk("R1 false start", {31'd0, rx_valid}, 32'd0);

    // table walk: formats, orders, parity, framing, glitch votes
    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      apply_cfg(v);
      send_frame(v, v.os16 ? 32 : 16);
      if (v.glitch) tag = "R2 data";
      else if (v.msb) tag = "R4 data";
      else if (!v.os16) tag = "R1 data";
      else tag = "R3 data";
      chk("R9 valid", {31'd0, rx_valid}, 32'd1);
      chk(tag, {23'd0, rx_data}, {23'd0, v.word & 9'((1 << v.nb) - 1)});
      chk("R5 parity", {31'd0, err_parity}, {31'd0, v.eperr});
      chk("R6 framing", {31'd0, err_frame}, {31'd0, v.eferr});
      chk("R8 no break", {31'd0, brk_det}, 32'd0);
      rd();
      chk("R9 read clears", {30'd0, rx_valid, err_frame}, 32'd0);
    end

    // R7 overrun
    v = mk(1'b0, 4'd8, 1'b0, 9'h011, 1'b0);
    apply_cfg(v);
    send_frame(v, 16);
    v.word = 9'h022;
    send_frame(v, 16);
    chk("R7 overrun", {31'd0, err_overrun}, 32'd1);
    chk("R7 newest data", {23'd0, rx_data}, 32'h22);
    rd();
    chk("R9 overrun cleared", {30'd0, err_overrun, rx_valid}, 32'd0);

    // R8 break, then held low, then recovery
    v = mk(1'b1, 4'd8, 1'b1, 9'h000, 1'b0);
    apply_cfg(v);
    for (int i = 0; i < 11 * 16 + 48; i++) smp(1'b0);
    chk("R8 break flag", {29'd0, rx_valid, brk_det, err_frame}, 32'h7);
    chk("R8 break data", {23'd0, rx_data}, 32'd0);
    rd();
    for (int i = 0; i < 48; i++) smp(1'b0);
    chk("R8 silent while low", {31'd0, rx_valid}, 32'd0);
    for (int i = 0; i < 32; i++) smp(1'b1);
    v.word = 9'h081;
    send_frame(v, 32);
    chk("R8 recovery data", {23'd0, rx_data}, 32'h81);
    chk("R8 recovery flags", {29'd0, brk_det, err_frame, err_parity}, 32'd0);
    rd();

    // R10 time-out boundary: 8x, 2 bit periods = 16 idle ticks after the stop vote
    v = mk(1'b0, 4'd8, 1'b0, 9'h05C, 1'b0);
    apply_cfg(v);
    cfg_to_bits = 8'd2;
    send_frame(v, 0);
    for (int i = 0; i < 13; i++) smp(1'b1);
    chk("R10 one tick early", {31'd0, rx_timeout}, 32'd0);
    smp(1'b1);
    chk("R10 at limit", {31'd0, rx_timeout}, 32'd1);
    for (int i = 0; i < 5; i++) smp(1'b1);
    chk("R10 sticky", {31'd0, rx_timeout}, 32'd1);
    rd();
    chk("R9 timeout cleared", {31'd0, rx_timeout}, 32'd0);
    for (int i = 0; i < 40; i++) smp(1'b1);
    chk("R10 once per char", {31'd0, rx_timeout}, 32'd0);

    // R11 zero count disables
    cfg_to_bits = 8'd0;
    send_frame(v, 0);
    for (int i = 0; i < 100; i++) smp(1'b1);
    chk("R11 disabled", {31'd0, rx_timeout}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule